// File: doc/BRIEF.md
# Smart-Card Interface Interrupt Register

This block gathers six event pulses from a smart-card interface and presents them to a processor. Five of the events appear in a main event register. The card insertion/extraction event appears in a register of its own. A six-bit mask register selects which pending events may drive the single interrupt line. Event detection, the character FIFO and the serial datapath live elsewhere. This block only records the pulses and applies the rules that clear them.

Each pending bit has its own clearing trigger, all taken from accesses on a simple synchronous strobe bus or from the line direction:

- Reading the main event register clears the three error-type bits (no answer to reset, character wait-time overflow, receive overflow).
- Writing the transmit data register clears the transmit-ready bit. The line turning from transmit to receive also clears it.
- Reading the receive data register clears the receive-available bit.
- Reading the card-change register clears the card bit.

An event arriving in the same cycle as its clear always wins, so no event is lost. The data registers themselves belong to another block; this one only watches accesses to their addresses.

Top module: `scif_irq_regs`

## Requirements
- R1: After reset every pending bit is 0, the mask register reads 6'h3F, and `irq` is 0.
- R2: A 1 on `src_evt[i]` sampled at a clock edge sets pending bit i. Source order is: 0 no-answer-to-reset, 1 wait-time overflow, 2 receive overflow, 3 transmit-ready, 4 receive-available, 5 card change. The main event register (address 0) shows bits 0..4 at the same positions.
- R3: A read returns the register value as it was before that read's own clearing. `bus_rdata` is loaded on the edge that samples `bus_rd`. Reading address 0 clears bits 0..2 and leaves bits 3 and 4 unchanged.
- R4: A write to the transmit data address (4) clears pending bit 3 and no other bit.
- R5: Pending bit 3 clears when `line_tx` goes from 1 (transmit) to 0 (receive). A change from 0 to 1 has no effect.
- R6: A read of the receive data address (3) clears pending bit 4 and no other bit. Such a read returns 0 from this block.
- R7: The card-change bit appears at bit 0 of the card register (address 1). Reading that register clears the bit.
- R8: A write to the mask address (2) loads `bus_wdata[5:0]`, with mask bit i belonging to source i. Reading address 2 returns the mask and clears nothing.
- R9: `irq` is 1 exactly when some pending bit i is 1 while mask bit i is 0. A mask bit of 1 blocks its source.
- R10: When an event and the access that would clear its bit fall in the same cycle, the bit is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | NSRC (6) | One-cycle event pulses, one per source |
| line_tx | input | 1 | Line direction, 1 = transmit, 0 = receive |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W (3) | Register address |
| bus_wdata | input | NSRC (6) | Write data (mask value) |
| bus_rdata | output | DATA_W (16) | Read data, registered |
| irq | output | 1 | Interrupt request |

## Verification
Pending bits and the mask change on the edge that samples the event, strobe or direction change. `bus_rdata` is loaded on that same edge, and `irq` follows the registered state without further delay. Every result is therefore due one edge after its stimulus. The bench drives inputs on the falling edge, holds them across exactly one rising edge, and samples outputs on the next falling edge. The sweeps cover all 64 event patterns and all 64 mask values, and expected register values and interrupt levels are computed arithmetically in the bench.

// File: rtl/scif_pkg.sv
package scif_pkg;
  localparam int NSRC      = 6;
  localparam int NMAIN     = 5;
  localparam int SRC_NOATR = 0;
  localparam int SRC_WAIT  = 1;
  localparam int SRC_OVRN  = 2;
  localparam int SRC_TXRDY = 3;
  localparam int SRC_RXAVL = 4;
  localparam int SRC_CARD  = 5;

  // register offsets on the strobe bus
  localparam int OFS_EVT  = 0;
  localparam int OFS_CARD = 1;
  localparam int OFS_MASK = 2;
  localparam int OFS_RXD  = 3;
  localparam int OFS_TXD  = 4;

  // interrupt request from pending flags and mask (1 = blocked)
  function automatic logic irq_of(input logic [NSRC-1:0] flags,
                                  input logic [NSRC-1:0] mask);
    return |(flags & ~mask);
  endfunction
endpackage

// File: rtl/scif_flag.sv
module scif_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> (q_o == $past(q_o)));
endmodule

// File: rtl/scif_clear_dec.sv
module scif_clear_dec
  import scif_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              line_tx,
  output logic [NSRC-1:0]   clr_o,
  output logic              dir_fall_o
);
  function automatic logic hit(input logic [ADDR_W-1:0] a, input int ofs);
    return a == ADDR_W'(ofs);
  endfunction

  logic dir_q;
  logic rd_evt, rd_card, rd_rxd, wr_txd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= 1'b0;
    else        dir_q <= line_tx;
  end

  assign dir_fall_o = dir_q && !line_tx;
  assign rd_evt     = bus_rd && hit(bus_addr, OFS_EVT);
  assign rd_card    = bus_rd && hit(bus_addr, OFS_CARD);
  assign rd_rxd     = bus_rd && hit(bus_addr, OFS_RXD);
  assign wr_txd     = bus_wr && hit(bus_addr, OFS_TXD);

  for (genvar i = 0; i < NSRC; i++) begin : g_clr
    if (i <= SRC_OVRN) begin : g_err
      assign clr_o[i] = rd_evt;
    end else if (i == SRC_TXRDY) begin : g_tx
      assign clr_o[i] = wr_txd || dir_fall_o;
    end else if (i == SRC_RXAVL) begin : g_rx
      assign clr_o[i] = rd_rxd;
    end else begin : g_cd
      assign clr_o[i] = rd_card;
    end
  end

  assert_dirfall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(line_tx) && !line_tx) |-> clr_o[SRC_TXRDY]);
  assert_rise_noclr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && line_tx) |-> !clr_o[SRC_TXRDY]);
endmodule

// File: rtl/scif_mask_reg.sv
module scif_mask_reg #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= '1;
    else if (wr_en) q_o <= wdata;
  end

  assert_mask_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (q_o == $past(wdata)));
  assert_mask_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q_o));
endmodule

// File: rtl/scif_irq_regs.sv
module scif_irq_regs
  import scif_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_evt,
  input  logic              line_tx,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NSRC-1:0]   bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic [NSRC-1:0] clr;
  logic [NSRC-1:0] flags;
  logic [NSRC-1:0] mask_q;
  logic            dir_fall;
  logic            mask_wr;
  logic [DATA_W-1:0] rd_mux;

  scif_clear_dec #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .line_tx(line_tx), .clr_o(clr), .dir_fall_o(dir_fall)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    scif_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set_i(src_evt[i]), .clr_i(clr[i]), .q_o(flags[i])
    );
  end

  assign mask_wr = bus_wr && (bus_addr == ADDR_W'(OFS_MASK));

  scif_mask_reg #(.W(NSRC)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_en(mask_wr), .wdata(bus_wdata), .q_o(mask_q)
  );

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(OFS_EVT))       rd_mux = DATA_W'(flags[NMAIN-1:0]);
    else if (bus_addr == ADDR_W'(OFS_CARD)) rd_mux = DATA_W'(flags[SRC_CARD]);
    else if (bus_addr == ADDR_W'(OFS_MASK)) rd_mux = DATA_W'(mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign irq = irq_of(flags, mask_q);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (flags == '0 && mask_q == '1 && !irq));
  assert_all_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1) |-> !irq);
  assert_none_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |-> !irq);
  assert_dirfall_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_fall && !src_evt[SRC_TXRDY]) |=> !flags[SRC_TXRDY]);
  assert_card_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(OFS_CARD) && !src_evt[SRC_CARD]) |=> !flags[SRC_CARD]);
endmodule

// File: tb/sim_scif_irq_regs.sv
module sim_scif_irq_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  src_evt = '0;
  logic        line_tx = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [5:0]  bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  scif_irq_regs u0 (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .line_tx(line_tx),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  localparam logic [2:0] A_EVT = 3'd0, A_CARD = 3'd1, A_MASK = 3'd2,
                         A_RXD = 3'd3, A_TXD = 3'd4;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_rd = 1'b1; bus_addr = a;
    cyc();
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [5:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    cyc();
    bus_wr = 1'b0;
  endtask

  task automatic fire(input logic [5:0] v);
    src_evt = v;
    cyc();
    src_evt = '0;
  endtask

  task automatic clear_all();
    logic [15:0] d;
    rd(A_EVT, d); rd(A_CARD, d); wr(A_TXD, 6'h0); rd(A_RXD, d);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 act=0 exp=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    check("R1 irq", irq, 0);
    rd(A_MASK, d); check("R1 mask", d, 16'h3F);
    rd(A_EVT, d);  check("R1 event reg", d, 0);
    rd(A_CARD, d); check("R1 card reg", d, 0);

    // R2/R3/R4/R6/R7/R9 sweep of all event patterns with all sources masked
    for (int p = 0; p < 64; p++) begin
      fire(6'(p));
      check("R9 masked irq", irq, 0);
      rd(A_EVT, d);  check("R2 event reg", d, p & 31);
      rd(A_EVT, d);  check("R3 after clear", d, p & 24);
      rd(A_CARD, d); check("R7 card reg", d, (p >> 5) & 1);
      rd(A_CARD, d); check("R7 card cleared", d, 0);
      wr(A_TXD, 6'h0);
      rd(A_EVT, d);  check("R4 tx write clears bit3 only", d, p & 16);
      rd(A_RXD, d);  check("R6 rx data returns 0", d, 0);
      rd(A_EVT, d);  check("R6 rx read clears bit4", d, 0);
    end

    // R8/R9 sweep of all mask values with every source pending
    fire(6'h3F);
    for (int m = 0; m < 64; m++) begin
      wr(A_MASK, 6'(m));
      rd(A_MASK, d); check("R8 mask readback", d, m);
      check("R9 irq vs mask", irq, ((~m) & 63) != 0);
    end
    rd(A_EVT, d); check("R8 mask read clears nothing", d, 31);
    clear_all();

    // R9 single source per mask position
    wr(A_MASK, 6'h00);
    for (int i = 0; i < 6; i++) begin
      fire(6'(1 << i));
      check("R9 single source irq", irq, 1);
      wr(A_MASK, 6'(1 << i));
      check("R8 own mask bit blocks", irq, 0);
      wr(A_MASK, 6'h00);
      clear_all();
      check("R9 cleared irq", irq, 0);
    end

    // R5 direction handling
    line_tx = 1'b1; cyc();
    fire(6'h08);
    line_tx = 1'b0; cyc();
    rd(A_EVT, d); check("R5 tx->rx clears bit3", d, 0);
    fire(6'h08);
    line_tx = 1'b1; cyc(); cyc();
    rd(A_EVT, d); check("R5 rx->tx keeps bit3", d, 8);
    line_tx = 1'b0; cyc();
    rd(A_EVT, d); check("R5 second fall clears", d, 0);

    // R10 event coinciding with its clear
    src_evt = 6'h01; rd(A_EVT, d); src_evt = '0;
    check("R10 read returns pre-clear value", d, 0);
    rd(A_EVT, d); check("R10 status collision", d, 1);
    src_evt = 6'h08; wr(A_TXD, 6'h0); src_evt = '0;
    rd(A_EVT, d); check("R10 tx collision", d, 8);
    wr(A_TXD, 6'h0);
    src_evt = 6'h10; rd(A_RXD, d); src_evt = '0;
    rd(A_EVT, d); check("R10 rx collision", d, 16);
    rd(A_RXD, d);
    src_evt = 6'h20; rd(A_CARD, d); src_evt = '0;
    rd(A_CARD, d); check("R10 card collision", d, 1);
    line_tx = 1'b1; cyc();
    src_evt = 6'h08; line_tx = 1'b0; cyc(); src_evt = '0;
    rd(A_EVT, d); check("R10 direction collision", d, 8);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule